// File: doc/BRIEF.md
# Word-to-Byte Memory Bus Bridge

This bridge connects a CPU that moves 16-bit words to a memory bus only one byte wide. Each CPU access is sorted by address. Internal fast memory covers two regions: the console scratch RAM window and the low ROM region. Any access there goes straight through, and `fast_en` marks it. Any other access goes to the byte-wide bus as two byte cycles in a row. The even (high-order) byte goes first and the odd (low-order) byte second. Each byte cycle has one wait cycle.

During a split access the bridge holds `cpu_ready` low. A read returns the two bytes joined into one word. A write has both of its bytes captured at the start, so the CPU may change its data lines during the wait cycles. A read followed by a write to the same word is two separate split accesses, and each one pays the full penalty.

Top module: `word_byte_bridge`

## Requirements
- R1: While reset is held and no access is requested, `cpu_ready` is 1, and `ext_en` and `fast_en` are both 0.
- R2: An access whose address lies in 0x8300..0x83FF or 0x0000..0x1FFF completes in 2 cycles. `cpu_ready` stays 1 throughout and `ext_en` never rises.
- R3: A fast-region read presents `fast_rdata` on `cpu_rdata` in its second cycle, and `fast_en` is 1 in both cycles.
- R4: Any other address takes 6 cycles. `cpu_ready` is 0 in cycles 1 to 5 and 1 in cycle 6.
- R5: A slow access drives the even byte first, at `ext_addr` = {addr[15:1],0}, in cycles 2 and 3. It then drives the odd byte, at {addr[15:1],1}, in cycles 4 and 5. CPU address bit 0 is ignored.
- R6: Each byte stays on the external bus for two cycles, one address cycle and one wait cycle, with address and write data unchanged.
- R7: A slow read returns {even byte, odd byte} on `cpu_rdata` in cycle 6.
- R8: A slow write drives `cpu_wdata[15:8]` for the even byte and `cpu_wdata[7:0]` for the odd byte. `ext_we` is 1 while `ext_en` is 1. Both bytes are taken in cycle 1, so changes on `cpu_wdata` after cycle 1 have no effect.
- R9: A read and then a write to the same slow word each take the full 6 cycles. The read returns the old word, and a later read returns the new one.
- R10: The fast/slow boundaries are exact. 0x82FE, 0x8400 and 0x2000 are slow. 0x8300, 0x83FF and 0x1FFE are fast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU byte address |
| cpu_memen | input | 1 | CPU access request, held until the access completes |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 16 | CPU write word |
| cpu_ready | output | 1 | 0 while the CPU must wait |
| cpu_rdata | output | 16 | Read word in the completing cycle |
| fast_en | output | 1 | Select for internal fast memory |
| fast_rdata | input | 16 | Read word from internal fast memory |
| ext_addr | output | 16 | Byte address on the narrow bus |
| ext_en | output | 1 | Narrow bus cycle active |
| ext_we | output | 1 | Narrow bus write strobe |
| ext_wdata | output | 8 | Narrow bus write byte |
| ext_rdata | input | 8 | Narrow bus read byte |

## Verification
The bench aims at the region edges just inside and just outside each fast window. A decoder with an off-by-one limit would give 2 cycles where 6 are due, or the reverse. It swaps the CPU write data after the first cycle. A bridge that does not capture both bytes would write the altered word. It reads at an odd address, which catches a bridge that lets address bit 0 pick the byte order. It also does a read, a write and a second read on one word, which exposes swapped byte lanes and a write that never reaches memory.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HI_ADR,
    ST_HI_WT,
    ST_LO_ADR,
    ST_LO_WT,
    ST_DONE,
    ST_FDONE
  } wbb_state_e;

  // Region test: inside the scratch window or at/below the ROM limit.
  function automatic logic addr_is_fast(input logic [31:0] a,
                                        input logic [31:0] sp_lo,
                                        input logic [31:0] sp_hi,
                                        input logic [31:0] rom_hi);
    return ((a >= sp_lo) && (a <= sp_hi)) || (a <= rom_hi);
  endfunction

endpackage

// File: rtl/wbb_region_dec.sv
module wbb_region_dec #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] SP_LO  = 16'h8300,
  parameter logic [ADDR_W-1:0] SP_HI  = 16'h83FF,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'h1FFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_fast
);
  import wbb_pkg::*;

  assign is_fast = addr_is_fast(32'(addr), 32'(SP_LO), 32'(SP_HI), 32'(ROM_HI));

endmodule

// File: rtl/wbb_seq.sv
module wbb_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_memen,
  input  logic is_fast,
  output logic start_slow,
  output logic cpu_ready,
  output logic fast_en,
  output logic bus_active,
  output logic byte_sel,
  output logic hi_cap,
  output logic lo_cap,
  output logic slow_done,
  output logic fast_done
);
  import wbb_pkg::*;

  wbb_state_e state_q, state_d;
  logic start_fast;

  assign start_slow = (state_q == ST_IDLE) && cpu_memen && !is_fast;
  assign start_fast = (state_q == ST_IDLE) && cpu_memen && is_fast;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_slow) state_d = ST_HI_ADR;
                 else if (start_fast) state_d = ST_FDONE;
      ST_HI_ADR: state_d = ST_HI_WT;
      ST_HI_WT:  state_d = ST_LO_ADR;
      ST_LO_ADR: state_d = ST_LO_WT;
      ST_LO_WT:  state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      ST_FDONE:  state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign bus_active = (state_q == ST_HI_ADR) || (state_q == ST_HI_WT) ||
                      (state_q == ST_LO_ADR) || (state_q == ST_LO_WT);
  assign byte_sel   = (state_q == ST_LO_ADR) || (state_q == ST_LO_WT);
  assign hi_cap     = (state_q == ST_HI_WT);
  assign lo_cap     = (state_q == ST_LO_WT);
  assign slow_done  = (state_q == ST_DONE);
  assign fast_done  = (state_q == ST_FDONE);
  assign cpu_ready  = !(start_slow || bus_active);
  assign fast_en    = start_fast || fast_done;

  // A slow access that has started must reach its byte cycles next.
  AST_SLOW_ENTERS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    start_slow |=> (bus_active && !byte_sel)) else $error("slow start"); // R4

endmodule

// File: rtl/wbb_datapath.sv
module wbb_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_slow,
  input  logic [ADDR_W-1:1] word_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              bus_active,
  input  logic              byte_sel,
  input  logic              hi_cap,
  input  logic              lo_cap,
  input  logic              slow_done,
  input  logic              fast_done,
  input  logic [DATA_W-1:0] fast_rdata,
  input  logic [DATA_W/2-1:0] ext_rdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_en,
  output logic              ext_we,
  output logic [DATA_W/2-1:0] ext_wdata,
  output logic [DATA_W-1:0] cpu_rdata
);
  localparam int BYTE_W = DATA_W / 2;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [DATA_W-1:0] w,
                                                  input logic odd);
    return odd ? w[BYTE_W-1:0] : w[DATA_W-1:BYTE_W];
  endfunction

  function automatic logic [DATA_W-1:0] join_bytes(input logic [BYTE_W-1:0] even_b,
                                                   input logic [BYTE_W-1:0] odd_b);
    return {even_b, odd_b};
  endfunction

  logic [ADDR_W-1:1] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic [BYTE_W-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b0;
      wd_q   <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (start_slow) begin
        addr_q <= word_addr;
        we_q   <= cpu_we;
        wd_q   <= cpu_wdata;
      end
      if (hi_cap) hi_q <= ext_rdata;
      if (lo_cap) lo_q <= ext_rdata;
    end
  end

  assign ext_en    = bus_active;
  assign ext_we    = bus_active && we_q;
  assign ext_addr  = bus_active ? {addr_q, byte_sel} : '0;
  assign ext_wdata = bus_active ? pick_byte(wd_q, byte_sel) : '0;
  assign cpu_rdata = slow_done ? join_bytes(hi_q, lo_q) :
                     fast_done ? fast_rdata : '0;

  // Write byte held across address and wait cycle of the same byte.
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_en && $past(ext_en) && $stable(ext_addr)) |-> $stable(ext_wdata))
    else $error("wdata moved"); // R6

endmodule

// File: rtl/word_byte_bridge.sv
module word_byte_bridge #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] SP_LO  = 16'h8300,
  parameter logic [ADDR_W-1:0] SP_HI  = 16'h83FF,
  parameter logic [ADDR_W-1:0] ROM_HI = 16'h1FFF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_memen,
  input  logic                cpu_we,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic                cpu_ready,
  output logic [DATA_W-1:0]   cpu_rdata,
  output logic                fast_en,
  input  logic [DATA_W-1:0]   fast_rdata,
  output logic [ADDR_W-1:0]   ext_addr,
  output logic                ext_en,
  output logic                ext_we,
  output logic [DATA_W/2-1:0] ext_wdata,
  input  logic [DATA_W/2-1:0] ext_rdata
);
  logic is_fast, start_slow, bus_active, byte_sel;
  logic hi_cap, lo_cap, slow_done, fast_done;

  wbb_region_dec #(.ADDR_W(ADDR_W), .SP_LO(SP_LO), .SP_HI(SP_HI), .ROM_HI(ROM_HI))
    u_dec (.addr(cpu_addr), .is_fast(is_fast));

  wbb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cpu_memen(cpu_memen), .is_fast(is_fast),
    .start_slow(start_slow), .cpu_ready(cpu_ready), .fast_en(fast_en),
    .bus_active(bus_active), .byte_sel(byte_sel), .hi_cap(hi_cap),
    .lo_cap(lo_cap), .slow_done(slow_done), .fast_done(fast_done)
  );

  wbb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .start_slow(start_slow),
    .word_addr(cpu_addr[ADDR_W-1:1]), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
    .bus_active(bus_active), .byte_sel(byte_sel), .hi_cap(hi_cap),
    .lo_cap(lo_cap), .slow_done(slow_done), .fast_done(fast_done),
    .fast_rdata(fast_rdata), .ext_rdata(ext_rdata), .ext_addr(ext_addr),
    .ext_en(ext_en), .ext_we(ext_we), .ext_wdata(ext_wdata),
    .cpu_rdata(cpu_rdata)
  );

  AST_FAST_NO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    fast_en |-> !ext_en) else $error("fast hit bus"); // R2
  AST_WAIT_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |-> !cpu_ready) else $error("ready during bus"); // R4
  AST_EVEN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_en) |-> !ext_addr[0]) else $error("odd first"); // R5
  AST_BYTE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_en) |=> (ext_en && $stable(ext_addr))) else $error("no wait"); // R6
  AST_DONE_AFTER_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_en) |-> (cpu_ready && $past(ext_addr[0]))) else $error("end"); // R7

endmodule

// File: tb/word_byte_bridge_tb_top.sv
module word_byte_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_memen = 1'b0;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        fast_en;
  logic [15:0] fast_rdata;
  logic [15:0] ext_addr;
  logic        ext_en, ext_we;
  logic [7:0]  ext_wdata, ext_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem    [256];
  logic [7:0] shadow [256];

  always #10 clk = ~clk;  // 50 MHz

  word_byte_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_memen(cpu_memen),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .fast_en(fast_en), .fast_rdata(fast_rdata),
    .ext_addr(ext_addr), .ext_en(ext_en), .ext_we(ext_we),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  // Byte-wide external memory model and internal fast memory model.
  assign ext_rdata  = mem[ext_addr[7:0]];
  assign fast_rdata = cpu_addr ^ 16'hA5C3;
  always @(posedge clk) if (ext_en && ext_we) mem[ext_addr[7:0]] <= ext_wdata;

  function automatic bit bench_fast(input logic [15:0] a);
    return (a[15:8] == 8'h83) || (a[15:13] == 3'b000);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {addr[33:18], write[17], wdata[16:1], swap_wdata_after_cycle1[0]}
  localparam logic [33:0] VEC [14] = '{
    {16'h8300, 1'b0, 16'h0000, 1'b0},  // R10 fast low edge
    {16'h83FF, 1'b0, 16'h0000, 1'b0},  // R10 fast high edge
    {16'h1FFE, 1'b0, 16'h0000, 1'b0},  // R10 ROM top
    {16'h82FE, 1'b0, 16'h0000, 1'b0},  // R10 below scratch
    {16'h8400, 1'b0, 16'h0000, 1'b0},  // R10 above scratch
    {16'h2000, 1'b0, 16'h0000, 1'b0},  // R10 above ROM
    {16'hA010, 1'b1, 16'h1234, 1'b0},  // R8 write
    {16'hA010, 1'b0, 16'h0000, 1'b0},  // R7 read back
    {16'hA011, 1'b0, 16'h0000, 1'b0},  // R5 odd address ignored
    {16'h0004, 1'b1, 16'hFFFF, 1'b0},  // R2 fast write stays off bus
    {16'hC020, 1'b1, 16'hBEEF, 1'b1},  // R8 data changed after cycle 1
    {16'hC020, 1'b0, 16'h0000, 1'b0},  // R8 read back
    {16'hD0F0, 1'b0, 16'h0000, 1'b0},  // R9 read before write
    {16'hD0F0, 1'b1, 16'h55AA, 1'b0}   // R9 write
  };

  task automatic run_access(input logic [15:0] a, input logic w,
                            input logic [15:0] wd, input bit swap);
    bit fast = bench_fast(a);
    int exp_cyc = fast ? 2 : 6;
    int cyc = 0;
    bit done = 0, bus_ok = 1, ext_seen = 0, fen_ok = 1;
    logic [15:0] got = '0, exp_rd;
    @(negedge clk);
    cpu_memen = 1'b1; cpu_addr = a; cpu_we = w; cpu_wdata = wd;
    while (!done && cyc < 40) begin
      cyc++;
      #1;
      if (!fast) begin
        bit e_en = (cyc >= 2) && (cyc <= 5);
        bit e_odd = (cyc >= 4);
        logic [7:0] e_b = e_odd ? wd[7:0] : wd[15:8];
        if (ext_en !== e_en) bus_ok = 0;
        if (e_en && (ext_addr !== {a[15:1], e_odd} || ext_we !== w)) bus_ok = 0;
        if (e_en && w && ext_wdata !== e_b) bus_ok = 0;
      end else begin
        if (ext_en) ext_seen = 1;
        if (!fast_en || !cpu_ready) fen_ok = 0;
      end
      if (cyc >= 2 && cpu_ready) begin done = 1; got = cpu_rdata; end
      @(negedge clk);
      if (swap && cyc == 1) cpu_wdata = ~wd;
    end
    cpu_memen = 1'b0;
    if (fast) begin
      check(cyc == exp_cyc, "R2 fast cycles", cyc, exp_cyc);
      check(!ext_seen, "R2 fast bus idle", 32'(ext_seen), 0);
      check(fen_ok, "R3 fast_en/ready", 32'(fen_ok), 1);
      if (!w) begin
        exp_rd = a ^ 16'hA5C3;
        check(got === exp_rd, "R3 fast rdata", got, exp_rd);
      end
    end else begin
      check(cyc == exp_cyc, "R4 R9 slow cycles", cyc, exp_cyc);
      check(bus_ok, "R5 R6 R8 byte sequence", 32'(bus_ok), 1);
      if (!w) begin
        exp_rd = {shadow[{a[7:1], 1'b0}], shadow[{a[7:1], 1'b1}]};
        check(got === exp_rd, "R7 R9 slow rdata", got, exp_rd);
      end else begin
        shadow[{a[7:1], 1'b0}] = wd[15:8];
        shadow[{a[7:1], 1'b1}] = wd[7:0];
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(cpu_ready === 1'b1, "R1 ready in reset", 32'(cpu_ready), 1);
    check(ext_en === 1'b0 && fast_en === 1'b0, "R1 selects in reset",
          {ext_en, fast_en}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 14; i++)
      run_access(VEC[i][33:18], VEC[i][17], VEC[i][16:1], VEC[i][0]);
    // R9 closing read: new word visible after the read-before-write pair
    run_access(16'hD0F0, 1'b0, 16'h0000, 1'b0);
    // R8 memory holds unswapped bytes, checked through a fresh read
    run_access(16'hC021, 1'b0, 16'h0000, 1'b0);
    repeat (2) @(negedge clk);
    check(cpu_ready === 1'b1 && ext_en === 1'b0, "R1 idle after traffic",
          {cpu_ready, ext_en}, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule